// File: doc/BRIEF.md
# Single-Buffered Two-Wire Bus Master Byte Sequencer

This block is the byte-level control for the only master on an I2C-compatible two-wire bus. Single-cycle task pulses start a write transfer, start a read transfer, request a stop, request a suspend and resume a suspended read. The sequencer asks for a start condition and sends the 7-bit slave address, most significant bit first, followed by the direction bit. After that it moves data one byte at a time. Outgoing bytes pass through one transmit holding register and incoming bytes through one receive holding register.

A separate bit timing engine produces the real SCL/SDA waveforms. The sequencer sends it one bit-level command at a time and waits for a one-cycle completion strobe. For read commands the completion strobe comes with the sampled line level. When software has not serviced a holding register, the sequencer issues no command and raises a hold output, and the timing engine keeps SCL low for as long as it is high. Software learns of progress through one-cycle event pulses.

Top module: `i2cByteSequencer`

## Requirements
- R1: After reset, bitReq, sclHold and all six event outputs are low.
- R2: A start-transmit pulse in idle produces a START command (bitCmd 0), then eight WRITE commands (bitCmd 2) carrying the address MSB first with direction bit 0, then one READ command (bitCmd 3) for the acknowledge. While bitReq is high and bitDone is low, bitCmd and bitWrData stay stable.
- R3: A start-receive pulse produces the same sequence with direction bit 1.
- R4: If the address acknowledge reads high (NACK), evError pulses and no data byte is sent. The sequencer then keeps sclHold high, with no bit command, until a stop task arrives.
- R5: A loaded transmit byte is sent as eight WRITE commands, MSB first, followed by one acknowledge READ. evTxSent pulses only after that acknowledge bit completes.
- R6: When the next write byte is due and no byte has been loaded since the last one was taken, sclHold is high and bitReq is low until txLoad.
- R7: A NACK on a written data byte pulses both evError and evTxSent. No further data byte is sent, even after txLoad, until the stop task.
- R8: A read byte is shifted in MSB first from eight READ commands and appears on rxByte. evRxReady then pulses, and sclHold stays high with no bit command until rxTake.
- R9: After rxTake, the master writes the acknowledge bit: 0 (ACK) if no stop or start task is pending, or 1 (NACK) if one is pending. After a NACK it issues STOP (bitCmd 1), or START if only a start is pending.
- R10: A start task given while a write waits for data, or given before a read byte is taken, produces a repeated START with no STOP in between. The new direction bit follows the new task.
- R11: evByteBound pulses once before each data byte, both sent and received.
- R12: A suspend task pending during a read takes effect after the next ACK bit. evSuspended pulses and sclHold stays high with no bit command until a resume task, after which the next byte is read.
- R13: A pending stop produces a STOP command. When it completes, evStopped pulses and the sequencer returns to idle with bitReq and sclHold low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| taskStartTx | input | 1 | Start write transfer pulse |
| taskStartRx | input | 1 | Start read transfer pulse |
| taskStop | input | 1 | Stop request pulse |
| taskSuspend | input | 1 | Suspend request pulse |
| taskResume | input | 1 | Resume pulse |
| slaveAddr | input | 7 | Slave address |
| txLoad | input | 1 | Write strobe for the transmit holding register |
| txByte | input | 8 | Byte for the transmit holding register |
| rxTake | input | 1 | Read strobe for the receive holding register |
| rxByte | output | 8 | Receive holding register |
| bitReq | output | 1 | Bit command valid, held until bitDone |
| bitCmd | output | 2 | 0 start, 1 stop, 2 write, 3 read |
| bitWrData | output | 1 | Level for a write command |
| bitDone | input | 1 | Bit command completed (one cycle) |
| bitRdVal | input | 1 | Sampled level for a read command, valid with bitDone |
| sclHold | output | 1 | Keep SCL low while servicing is pending |
| evByteBound | output | 1 | Pulse before each data byte |
| evTxSent | output | 1 | Pulse after a byte and its acknowledge |
| evRxReady | output | 1 | Pulse when a received byte is stored |
| evError | output | 1 | Pulse on a NACK from the slave |
| evStopped | output | 1 | Pulse after the stop condition |
| evSuspended | output | 1 | Pulse on entering suspend |

## Verification
A wrong sequencer state shows up at the bit-command port within one bit time: an extra, missing or misordered command, or a wrong acknowledge level, changes the logged command stream right away. A stuck holding-register flag shows as sclHold staying high, or as a byte sent without txLoad, in the same cycle the next byte would start. A lost pending stop, start or suspend shows up as the wrong command following the next acknowledge bit, and as a missing or extra stopped or suspended pulse.

// File: rtl/i2cSeqPkg.sv
package i2cSeqPkg;

  typedef enum logic [1:0] {
    BIT_START = 2'd0,
    BIT_STOP  = 2'd1,
    BIT_WRITE = 2'd2,
    BIT_READ  = 2'd3
  } bitCmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_ADDRACK, S_TXWAIT, S_TXBITS, S_TXACK,
    S_RXBITS, S_RXWAIT, S_RXACK, S_SUSP, S_NACKHOLD, S_STOP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic addrDir;
    logic loadTx;
    logic shiftOut;
    logic shiftIn;
    logic storeRx;
    logic clrCnt;
  } dpStrobe_t;

endpackage

// File: rtl/i2cSeqDatapath.sv
module i2cSeqDatapath
  import i2cSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              txLoad,
  input  logic [DATA_W-1:0] txByte,
  input  logic              rxTake,
  input  logic              bitRdVal,
  output logic [DATA_W-1:0] rxByte,
  output logic              txFull,
  output logic              rxFull,
  output logic              lastBit,
  output logic              txBit
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] txHold;
  logic [DATA_W-1:0] rxHold;
  logic [DATA_W-1:0] addrFrame;
  logic [DATA_W-1:0] shiftedIn;
  logic [CNT_W-1:0]  bitCnt;

  generate
    if (DATA_W == ADDR_W + 1) begin : gAddrFit
      assign addrFrame = {slaveAddr, strb.addrDir};
    end else begin : gAddrPad
      assign addrFrame = {slaveAddr, strb.addrDir, {(DATA_W - ADDR_W - 1){1'b0}}};
    end
  endgenerate

  assign shiftedIn = {shiftReg[DATA_W-2:0], bitRdVal};
  assign lastBit   = (bitCnt == LAST_IDX);
  assign txBit     = shiftReg[DATA_W-1];
  assign rxByte    = rxHold;

  // shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.loadAddr) begin
      shiftReg <= addrFrame;
      bitCnt   <= '0;
    end else if (strb.loadTx) begin
      shiftReg <= txHold;
      bitCnt   <= '0;
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      bitCnt   <= bitCnt + 1'b1;
    end else if (strb.shiftIn) begin
      shiftReg <= shiftedIn;
      bitCnt   <= bitCnt + 1'b1;
    end else if (strb.clrCnt) begin
      bitCnt   <= '0;
    end
  end

  // transmit holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
    end else if (txLoad) begin
      txHold <= txByte;
      txFull <= 1'b1;
    end else if (strb.loadTx) begin
      txFull <= 1'b0;
    end
  end

  // receive holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold <= '0;
      rxFull <= 1'b0;
    end else if (strb.storeRx) begin
      rxHold <= shiftedIn;
      rxFull <= 1'b1;
    end else if (rxTake) begin
      rxFull <= 1'b0;
    end
  end

endmodule

// File: rtl/i2cSeqControl.sv
module i2cSeqControl
  import i2cSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      taskStartTx,
  input  logic      taskStartRx,
  input  logic      taskStop,
  input  logic      taskSuspend,
  input  logic      taskResume,
  input  logic      bitDone,
  input  logic      bitRdVal,
  input  logic      txFull,
  input  logic      rxFull,
  input  logic      lastBit,
  input  logic      txBit,
  output dpStrobe_t strb,
  output logic      bitReq,
  output logic [1:0] bitCmd,
  output logic      bitWrData,
  output logic      sclHold,
  output logic      evByteBound,
  output logic      evTxSent,
  output logic      evRxReady,
  output logic      evError,
  output logic      evStopped,
  output logic      evSuspended
);

  seqState_t state, nxt;
  logic curDir, pendDir;
  logic stopPend, startPend, suspPend;
  logic ackBit, ackNext;
  logic takeStop, takeStart, takeSusp;
  logic bbN, txN, rxN, errN, stopN, suspN;
  logic anyStart;

  assign anyStart = taskStartTx | taskStartRx;

  always_comb begin
    nxt       = state;
    strb      = '0;
    strb.addrDir = curDir;
    ackNext   = ackBit;
    takeStop  = 1'b0;
    takeStart = 1'b0;
    takeSusp  = 1'b0;
    bbN = 1'b0; txN = 1'b0; rxN = 1'b0; errN = 1'b0; stopN = 1'b0; suspN = 1'b0;
    case (state)
      S_IDLE:    if (anyStart) nxt = S_START;
      S_START:   if (bitDone) begin strb.loadAddr = 1'b1; nxt = S_ADDR; end
      S_ADDR:    if (bitDone) begin
                   strb.shiftOut = 1'b1;
                   if (lastBit) nxt = S_ADDRACK;
                 end
      S_ADDRACK: if (bitDone) begin
                   if (bitRdVal) begin
                     errN = 1'b1;
                     nxt  = S_NACKHOLD;
                   end else if (curDir) begin
                     strb.clrCnt = 1'b1;
                     bbN = 1'b1;
                     nxt = S_RXBITS;
                   end else begin
                     nxt = S_TXWAIT;
                   end
                 end
      S_TXWAIT:  if (txFull) begin
                   strb.loadTx = 1'b1;
                   bbN = 1'b1;
                   nxt = S_TXBITS;
                 end else if (stopPend) begin
                   takeStop = 1'b1;
                   nxt = S_STOP;
                 end else if (startPend) begin
                   takeStart = 1'b1;
                   nxt = S_START;
                 end
      S_TXBITS:  if (bitDone) begin
                   strb.shiftOut = 1'b1;
                   if (lastBit) nxt = S_TXACK;
                 end
      S_TXACK:   if (bitDone) begin
                   txN = 1'b1;
                   if (bitRdVal) begin
                     errN = 1'b1;
                     nxt  = S_NACKHOLD;
                   end else begin
                     nxt = S_TXWAIT;
                   end
                 end
      S_RXBITS:  if (bitDone) begin
                   strb.shiftIn = 1'b1;
                   if (lastBit) begin
                     strb.storeRx = 1'b1;
                     rxN = 1'b1;
                     nxt = S_RXWAIT;
                   end
                 end
      S_RXWAIT:  if (!rxFull) begin
                   ackNext = stopPend | startPend;
                   nxt = S_RXACK;
                 end
      S_RXACK:   if (bitDone) begin
                   if (ackBit) begin
                     if (stopPend) begin
                       takeStop = 1'b1;
                       nxt = S_STOP;
                     end else begin
                       takeStart = 1'b1;
                       nxt = S_START;
                     end
                   end else if (suspPend) begin
                     takeSusp = 1'b1;
                     suspN = 1'b1;
                     nxt = S_SUSP;
                   end else begin
                     strb.clrCnt = 1'b1;
                     bbN = 1'b1;
                     nxt = S_RXBITS;
                   end
                 end
      S_SUSP:    if (taskResume) begin
                   strb.clrCnt = 1'b1;
                   bbN = 1'b1;
                   nxt = S_RXBITS;
                 end
      S_NACKHOLD: if (stopPend) begin
                   takeStop = 1'b1;
                   nxt = S_STOP;
                 end
      S_STOP:    if (bitDone) begin
                   stopN = 1'b1;
                   nxt = S_IDLE;
                 end
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      curDir    <= 1'b0;
      pendDir   <= 1'b0;
      stopPend  <= 1'b0;
      startPend <= 1'b0;
      suspPend  <= 1'b0;
      ackBit    <= 1'b0;
    end else begin
      state  <= nxt;
      ackBit <= ackNext;
      if (state == S_IDLE) begin
        stopPend  <= 1'b0;
        startPend <= 1'b0;
        suspPend  <= 1'b0;
        if (anyStart) curDir <= ~taskStartTx;
      end else begin
        if (takeStop) stopPend <= 1'b0;
        else if (taskStop) stopPend <= 1'b1;
        if (takeStart) begin
          startPend <= 1'b0;
          curDir    <= pendDir;
        end else if (anyStart) begin
          startPend <= 1'b1;
          pendDir   <= ~taskStartTx;
        end
        if (takeSusp) suspPend <= 1'b0;
        else if (taskSuspend) suspPend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evByteBound <= 1'b0;
      evTxSent    <= 1'b0;
      evRxReady   <= 1'b0;
      evError     <= 1'b0;
      evStopped   <= 1'b0;
      evSuspended <= 1'b0;
    end else begin
      evByteBound <= bbN;
      evTxSent    <= txN;
      evRxReady   <= rxN;
      evError     <= errN;
      evStopped   <= stopN;
      evSuspended <= suspN;
    end
  end

  always_comb begin
    bitReq = 1'b1;
    bitCmd = BIT_READ;
    case (state)
      S_START:                     bitCmd = BIT_START;
      S_STOP:                      bitCmd = BIT_STOP;
      S_ADDR, S_TXBITS, S_RXACK:   bitCmd = BIT_WRITE;
      S_ADDRACK, S_TXACK, S_RXBITS: bitCmd = BIT_READ;
      default:                     bitReq = 1'b0;
    endcase
  end

  assign bitWrData = (state == S_RXACK) ? ackBit : txBit;
  assign sclHold   = ((state == S_TXWAIT) && !txFull) ||
                     ((state == S_RXWAIT) && rxFull) ||
                     (state == S_SUSP) || (state == S_NACKHOLD);

endmodule

// File: rtl/i2cByteSequencer.sv
module i2cByteSequencer
  import i2cSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              taskStartTx,
  input  logic              taskStartRx,
  input  logic              taskStop,
  input  logic              taskSuspend,
  input  logic              taskResume,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              txLoad,
  input  logic [DATA_W-1:0] txByte,
  input  logic              rxTake,
  output logic [DATA_W-1:0] rxByte,
  output logic              bitReq,
  output logic [1:0]        bitCmd,
  output logic              bitWrData,
  input  logic              bitDone,
  input  logic              bitRdVal,
  output logic              sclHold,
  output logic              evByteBound,
  output logic              evTxSent,
  output logic              evRxReady,
  output logic              evError,
  output logic              evStopped,
  output logic              evSuspended
);

  dpStrobe_t strb;
  logic txFull, rxFull, lastBit, txBit;

  i2cSeqDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .slaveAddr(slaveAddr),
    .txLoad(txLoad), .txByte(txByte), .rxTake(rxTake), .bitRdVal(bitRdVal),
    .rxByte(rxByte), .txFull(txFull), .rxFull(rxFull),
    .lastBit(lastBit), .txBit(txBit)
  );

  i2cSeqControl uCtl (
    .clk(clk), .rstN(rstN),
    .taskStartTx(taskStartTx), .taskStartRx(taskStartRx), .taskStop(taskStop),
    .taskSuspend(taskSuspend), .taskResume(taskResume),
    .bitDone(bitDone), .bitRdVal(bitRdVal),
    .txFull(txFull), .rxFull(rxFull), .lastBit(lastBit), .txBit(txBit),
    .strb(strb), .bitReq(bitReq), .bitCmd(bitCmd), .bitWrData(bitWrData),
    .sclHold(sclHold), .evByteBound(evByteBound), .evTxSent(evTxSent),
    .evRxReady(evRxReady), .evError(evError), .evStopped(evStopped),
    .evSuspended(evSuspended)
  );

endmodule

// File: rtl/i2cSeqChecker.sv
module i2cSeqChecker
  import i2cSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              taskStartTx,
  input logic              taskStartRx,
  input logic              taskStop,
  input logic              taskSuspend,
  input logic              taskResume,
  input logic [ADDR_W-1:0] slaveAddr,
  input logic              txLoad,
  input logic [DATA_W-1:0] txByte,
  input logic              rxTake,
  input logic [DATA_W-1:0] rxByte,
  input logic              bitReq,
  input logic [1:0]        bitCmd,
  input logic              bitWrData,
  input logic              bitDone,
  input logic              bitRdVal,
  input logic              sclHold,
  input logic              evByteBound,
  input logic              evTxSent,
  input logic              evRxReady,
  input logic              evError,
  input logic              evStopped,
  input logic              evSuspended
);

  assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bitReq && !bitDone) |=> (bitReq && $stable(bitCmd) && $stable(bitWrData)));

  assert_error_after_nack_R4: assert property (@(posedge clk) disable iff (!rstN)
    evError |-> ($past(bitDone && bitRdVal) && ($past(bitCmd) == BIT_READ)));

  assert_txsent_after_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    evTxSent |-> ($past(bitDone) && ($past(bitCmd) == BIT_READ)));

  assert_hold_no_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    sclHold |-> !bitReq);

  assert_rxready_after_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    evRxReady |-> ($past(bitDone) && ($past(bitCmd) == BIT_READ)));

  assert_events_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evByteBound, evTxSent, evRxReady, evStopped, evSuspended}));

  assert_suspend_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    evSuspended |-> sclHold);

  assert_stopped_after_stop_R13: assert property (@(posedge clk) disable iff (!rstN)
    evStopped |-> ($past(bitDone) && ($past(bitCmd) == BIT_STOP) && !bitReq));

endmodule

bind i2cByteSequencer i2cSeqChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_i2cByteSequencer.sv
`timescale 1ns/1ps
module tb_i2cByteSequencer;

  localparam int C_START = 0, C_STOP = 1, C_W0 = 2, C_W1 = 3, C_RD = 4;
  localparam int P_TX = 0, P_RX = 1, P_STOP = 2, P_SUSP = 3, P_RES = 4;
  localparam int E_BB = 0, E_TX = 1, E_RX = 2, E_ERR = 3, E_STOP = 4, E_SUSP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic taskStartTx = 0, taskStartRx = 0, taskStop = 0, taskSuspend = 0, taskResume = 0;
  logic [6:0] slaveAddr = '0;
  logic txLoad = 0;
  logic [7:0] txByte = '0;
  logic rxTake = 0;
  logic [7:0] rxByte;
  logic bitReq;
  logic [1:0] bitCmd;
  logic bitWrData;
  logic bitDone = 0;
  logic bitRdVal = 0;
  logic sclHold;
  logic evByteBound, evTxSent, evRxReady, evError, evStopped, evSuspended;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  i2cByteSequencer dut (
    .clk(clk), .rstN(rstN),
    .taskStartTx(taskStartTx), .taskStartRx(taskStartRx), .taskStop(taskStop),
    .taskSuspend(taskSuspend), .taskResume(taskResume),
    .slaveAddr(slaveAddr), .txLoad(txLoad), .txByte(txByte), .rxTake(rxTake),
    .rxByte(rxByte), .bitReq(bitReq), .bitCmd(bitCmd), .bitWrData(bitWrData),
    .bitDone(bitDone), .bitRdVal(bitRdVal), .sclHold(sclHold),
    .evByteBound(evByteBound), .evTxSent(evTxSent), .evRxReady(evRxReady),
    .evError(evError), .evStopped(evStopped), .evSuspended(evSuspended)
  );

  // bit timing engine and slave model: logs commands, answers reads
  logic [2:0] logArr [0:511];
  int logN = 0;
  logic rdBits [0:511];
  int rdN = 0;
  int rdPtr = 0;
  int engCnt = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      bitDone = 0;
      engCnt  = 0;
    end else if (bitDone) begin
      bitDone = 0;
    end else if (bitReq) begin
      engCnt = engCnt + 1;
      if (engCnt == 3) begin
        engCnt = 0;
        bitDone = 1;
        case (bitCmd)
          2'd0: logArr[logN] = 3'(C_START);
          2'd1: logArr[logN] = 3'(C_STOP);
          2'd2: logArr[logN] = bitWrData ? 3'(C_W1) : 3'(C_W0);
          default: begin
            logArr[logN] = 3'(C_RD);
            bitRdVal = (rdPtr < rdN) ? rdBits[rdPtr] : 1'b1;
            rdPtr = rdPtr + 1;
          end
        endcase
        logN = logN + 1;
      end
    end
  end

  int cBB = 0, cTx = 0, cRx = 0, cErr = 0, cStop = 0, cSusp = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (evByteBound) cBB++;
      if (evTxSent)    cTx++;
      if (evRxReady)   cRx++;
      if (evError)     cErr++;
      if (evStopped)   cStop++;
      if (evSuspended) cSusp++;
    end
  end

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic [2:0] expArr [0:511];
  int expN = 0;
  int logBase = 0;

  task automatic expClear();
    expN = 0;
    logBase = logN;
  endtask
  task automatic expPush(input int c);
    expArr[expN] = 3'(c);
    expN++;
  endtask
  task automatic expByteOut(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) expPush(b[i] ? C_W1 : C_W0);
  endtask
  task automatic expReads(input int n);
    for (int i = 0; i < n; i++) expPush(C_RD);
  endtask
  task automatic compareLog(input string req);
    int firstBad = -1;
    check(req, "command count", logN - logBase, expN);
    for (int i = 0; i < expN; i++)
      if (firstBad < 0 && logArr[logBase + i] != expArr[i]) firstBad = i;
    check(req, "first mismatching command index", firstBad, -1);
  endtask

  task automatic rdPush(input logic b);
    rdBits[rdN] = b;
    rdN++;
  endtask
  task automatic rdByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) rdPush(b[i]);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      P_TX:   taskStartTx = 1;
      P_RX:   taskStartRx = 1;
      P_STOP: taskStop = 1;
      P_SUSP: taskSuspend = 1;
      default: taskResume = 1;
    endcase
    @(negedge clk);
    taskStartTx = 0; taskStartRx = 0; taskStop = 0; taskSuspend = 0; taskResume = 0;
  endtask

  task automatic loadTx(input logic [7:0] b);
    @(negedge clk);
    txLoad = 1;
    txByte = b;
    @(negedge clk);
    txLoad = 0;
  endtask

  task automatic takeRx();
    @(negedge clk);
    rxTake = 1;
    @(negedge clk);
    rxTake = 0;
  endtask

  function automatic int evCount(input int which);
    case (which)
      E_BB:   return cBB;
      E_TX:   return cTx;
      E_RX:   return cRx;
      E_ERR:  return cErr;
      E_STOP: return cStop;
      default: return cSusp;
    endcase
  endfunction

  task automatic waitEv(input int which, input int target);
    int n = 0;
    while (evCount(which) < target && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "bitReq", int'(bitReq), 0);
    check("R1", "sclHold", int'(sclHold), 0);
    check("R1", "events", int'({evByteBound, evTxSent, evRxReady, evError, evStopped, evSuspended}), 0);
  endtask

  task automatic testWrite();
    int b0 = cBB, t0 = cTx, s0 = cStop, e0 = cErr, mark;
    expClear();
    slaveAddr = 7'h52;
    rdPush(0); rdPush(0); rdPush(0);
    loadTx(8'hA5);
    pulse(P_TX);
    waitEv(E_TX, t0 + 1);
    idleCycles(12);
    mark = logN - logBase;
    check("R6", "sclHold while empty", int'(sclHold), 1);
    check("R6", "bitReq while empty", int'(bitReq), 0);
    check("R5", "commands at first byte sent", mark, 19);
    idleCycles(20);
    check("R6", "no commands while empty", logN - logBase, mark);
    loadTx(8'h3C);
    waitEv(E_TX, t0 + 2);
    pulse(P_STOP);
    waitEv(E_STOP, s0 + 1);
    @(negedge clk);
    check("R13", "bitReq after stop", int'(bitReq), 0);
    check("R13", "sclHold after stop", int'(sclHold), 0);
    check("R13", "stopped pulses", cStop - s0, 1);
    check("R5", "bytes sent events", cTx - t0, 2);
    check("R11", "byte boundary events on write", cBB - b0, 2);
    check("R5", "no error", cErr - e0, 0);
    expPush(C_START); expByteOut(8'hA4); expReads(1);
    expByteOut(8'hA5); expReads(1); expByteOut(8'h3C); expReads(1); expPush(C_STOP);
    compareLog("R2");
  endtask

  task automatic testAddrNack();
    int e0 = cErr, t0 = cTx, s0 = cStop;
    expClear();
    slaveAddr = 7'h52;
    rdPush(1);
    loadTx(8'h11);
    pulse(P_TX);
    waitEv(E_ERR, e0 + 1);
    idleCycles(20);
    check("R4", "commands after address nack", logN - logBase, 10);
    check("R4", "sclHold in nack hold", int'(sclHold), 1);
    check("R4", "bitReq in nack hold", int'(bitReq), 0);
    check("R4", "no byte sent", cTx - t0, 0);
    pulse(P_STOP);
    waitEv(E_STOP, s0 + 1);
    expPush(C_START); expByteOut(8'hA4); expReads(1); expPush(C_STOP);
    compareLog("R4");
  endtask

  task automatic testDataNack();
    int e0 = cErr, t0 = cTx, s0 = cStop;
    expClear();
    slaveAddr = 7'h19;
    rdPush(0); rdPush(1);
    loadTx(8'h0F);
    pulse(P_TX);
    waitEv(E_ERR, e0 + 1);
    check("R7", "sent event with nack", cTx - t0, 1);
    loadTx(8'h77);
    idleCycles(30);
    check("R7", "commands after data nack", logN - logBase, 19);
    check("R7", "sclHold after data nack", int'(sclHold), 1);
    pulse(P_STOP);
    waitEv(E_STOP, s0 + 1);
    expPush(C_START); expByteOut(8'h32); expReads(1);
    expByteOut(8'h0F); expReads(1); expPush(C_STOP);
    compareLog("R7");
  endtask

  task automatic testRead();
    int r0 = cRx, s0 = cStop, b0 = cBB, mark;
    expClear();
    slaveAddr = 7'h2B;
    rdPush(0); rdByte(8'hC3); rdByte(8'h5E);
    pulse(P_RX);
    waitEv(E_RX, r0 + 1);
    check("R8", "first byte", int'(rxByte), 8'hC3);
    idleCycles(15);
    mark = logN - logBase;
    check("R8", "sclHold while unread", int'(sclHold), 1);
    check("R8", "bitReq while unread", int'(bitReq), 0);
    check("R8", "commands while unread", mark, 18);
    takeRx();
    waitEv(E_RX, r0 + 2);
    check("R8", "second byte", int'(rxByte), 8'h5E);
    pulse(P_STOP);
    takeRx();
    waitEv(E_STOP, s0 + 1);
    check("R11", "byte boundary events on read", cBB - b0, 2);
    expPush(C_START); expByteOut(8'h57); expReads(1);
    expReads(8); expPush(C_W0); expReads(8); expPush(C_W1); expPush(C_STOP);
    compareLog("R9");
    check("R3", "direction bit is read", int'(logArr[logBase + 8]), C_W1);
  endtask

  task automatic testRestartWriteRead();
    int t0 = cTx, r0 = cRx, s0 = cStop;
    expClear();
    slaveAddr = 7'h40;
    rdPush(0); rdPush(0); rdPush(0); rdByte(8'h6D);
    loadTx(8'h99);
    pulse(P_TX);
    waitEv(E_TX, t0 + 1);
    pulse(P_RX);
    waitEv(E_RX, r0 + 1);
    check("R10", "byte after repeated start", int'(rxByte), 8'h6D);
    pulse(P_STOP);
    takeRx();
    waitEv(E_STOP, s0 + 1);
    check("R10", "single stopped pulse", cStop - s0, 1);
    expPush(C_START); expByteOut(8'h80); expReads(1); expByteOut(8'h99); expReads(1);
    expPush(C_START); expByteOut(8'h81); expReads(1); expReads(8); expPush(C_W1);
    expPush(C_STOP);
    compareLog("R10");
  endtask

  task automatic testRestartReadWrite();
    int r0 = cRx, s0 = cStop;
    expClear();
    slaveAddr = 7'h10;
    rdPush(0); rdByte(8'hF0); rdPush(0);
    pulse(P_RX);
    waitEv(E_RX, r0 + 1);
    pulse(P_TX);
    takeRx();
    idleCycles(300);
    check("R6", "hold after restart to write", int'(sclHold), 1);
    pulse(P_STOP);
    waitEv(E_STOP, s0 + 1);
    expPush(C_START); expByteOut(8'h21); expReads(1); expReads(8); expPush(C_W1);
    expPush(C_START); expByteOut(8'h20); expReads(1); expPush(C_STOP);
    compareLog("R10");
  endtask

  task automatic testSuspend();
    int r0 = cRx, s0 = cStop, u0 = cSusp, b0 = cBB, mark;
    expClear();
    slaveAddr = 7'h33;
    rdPush(0); rdByte(8'h12); rdByte(8'h34);
    pulse(P_RX);
    pulse(P_SUSP);
    waitEv(E_RX, r0 + 1);
    check("R8", "byte before suspend", int'(rxByte), 8'h12);
    takeRx();
    waitEv(E_SUSP, u0 + 1);
    mark = logN - logBase;
    check("R12", "commands at suspend", mark, 19);
    check("R12", "ack before suspend", int'(logArr[logN - 1]), C_W0);
    idleCycles(25);
    check("R12", "sclHold in suspend", int'(sclHold), 1);
    check("R12", "bitReq in suspend", int'(bitReq), 0);
    check("R12", "no commands in suspend", logN - logBase, mark);
    pulse(P_RES);
    waitEv(E_RX, r0 + 2);
    check("R12", "byte after resume", int'(rxByte), 8'h34);
    pulse(P_STOP);
    takeRx();
    waitEv(E_STOP, s0 + 1);
    check("R11", "byte boundary with suspend", cBB - b0, 2);
    expPush(C_START); expByteOut(8'h67); expReads(1); expReads(8); expPush(C_W0);
    expReads(8); expPush(C_W1); expPush(C_STOP);
    compareLog("R12");
  endtask

  initial begin
    idleCycles(5);
    testReset();
    rstN = 1;
    idleCycles(3);
    testReset();
    testWrite();
    testAddrNack();
    testDataNack();
    testRead();
    testRestartWriteRead();
    testRestartReadWrite();
    testSuspend();
    idleCycles(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule